// File: doc/BRIEF.md
# Multiplexed Display Digit Scanner

The scanner drives a four-digit, common-switched seven-segment display from a single fast scan clock. A chain of falling-edge toggle flip-flops divides the scan clock. The two most significant stages of that chain form a two-bit selector that steps through the digits in order. The selector chooses one of the four BCD inputs. That value goes through a seven-segment decoder, and the selector also drives a 2-to-4 one-hot decoder for the digit commons.

Both the digit enables and the segment lines leave the block from flip-flops, so combinational decode glitches never reach the display. Each time the selector moves to a new digit, the block first turns every digit off for one scan-clock cycle. During that cycle it loads the new digit's segment pattern, and only afterwards does it enable the new digit. This removes ghosting between adjacent digits.

The BCD inputs are level signals that the block samples on every rising edge. No flow control applies: there is no valid/ready pair and no back-pressure, and a new value simply appears on the display within one cycle while its digit is lit.

Top module: `digit_scanner`

## Requirements
- R1: While `rst_ni` is low, `en_o` and `seg_o` are all zero and the selector is forced to digit 0. After release, the first rising edge of `clk_i` lights digit 0 (`en_o` = 4'b0001).
- R2: Digits are visited in the order 0, 1, 2, 3, 0, and so on. Each selector value is held for 2**`DWELL_LOG2` scan-clock cycles, with `DWELL_LOG2` at least 1.
- R3: At most one bit of `en_o` is high in any cycle.
- R4: Bit k of `en_o` lights digit k, and digit k is taken from `digits_i[4k+3:4k]`.
- R5: Between two different lit digits there is exactly one cycle with `en_o` all zero. One lit digit never changes directly to another.
- R6: While digit k is lit, `seg_o` shows the decode of the value that `digits_i[4k+3:4k]` held at the previous rising edge. Bit 0 of `seg_o` is segment a, and so on up to bit 6, which is segment g; all lines are active-high. Digits 0 to 9 map to 0x3F, 0x06, 0x5B, 0x4F, 0x66, 0x6D, 0x7D, 0x07, 0x7F and 0x6F.
- R7: In the blank cycle, `seg_o` already carries the pattern of the digit about to be lit.
- R8: A BCD value from 10 to 15 drives all seven segment lines low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Scan clock; the selector advances on falling edges and the outputs update on rising edges |
| rst_ni | input | 1 | Asynchronous active-low reset |
| digits_i | input | 16 | Four BCD digits; digit k occupies bits 4k+3 down to 4k |
| en_o | output | 4 | Registered one-hot digit-common enables, active-high |
| seg_o | output | 7 | Registered segment lines a (bit 0) to g (bit 6), active-high |

## Verification
The properties assume `DWELL_LOG2` is at least 1, so that each selector value lasts longer than the blank cycle. They also assume that reset is applied once before scanning begins. The segment property compares `seg_o` against the digit inputs one cycle earlier, so it takes for granted that `digits_i` is stable around each rising edge. The bench keeps within these limits: it changes `digits_i` only just after a falling edge. Its patterns include held values, out-of-range codes and changes every few cycles that land in the middle of a digit's lit window.

// File: rtl/scan_pkg.sv
package scan_pkg;
  localparam int NUM_DIGITS = 4;
  localparam int SEL_W      = $clog2(NUM_DIGITS);
  localparam int BCD_W      = 4;
  localparam int SEG_W      = 7;
  localparam int BUS_W      = NUM_DIGITS * BCD_W;

  typedef logic [SEL_W-1:0]      sel_t;
  typedef logic [BCD_W-1:0]      bcd_t;
  typedef logic [SEG_W-1:0]      seg_t;
  typedef logic [NUM_DIGITS-1:0] en_t;
endpackage

// File: rtl/scan_toggle_ff.sv
// One divider stage: flips its state on each falling edge of its clock input.
module scan_toggle_ff (
  input  logic clk_i,
  input  logic rst_ni,
  output logic q_o
);
  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) q_o <= 1'b0;
    else         q_o <= ~q_o;
  end
endmodule

// File: rtl/scan_ripple_sel.sv
// Ripple divider: stage 0 runs from the scan clock and each later stage from
// the output of the stage below it. The top SEL_W stages form the selector.
module scan_ripple_sel
  import scan_pkg::*;
#(
  parameter int unsigned STAGES = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  output sel_t sel_o
);
  logic [STAGES-1:0] stage_q;
  logic [STAGES-1:0] stage_clk;

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      assign stage_clk[i] = clk_i;
    end else begin : g_next
      assign stage_clk[i] = stage_q[i-1];
    end
    scan_toggle_ff u_tff (
      .clk_i (stage_clk[i]),
      .rst_ni(rst_ni),
      .q_o   (stage_q[i])
    );
  end

  assign sel_o = stage_q[STAGES-1 -: SEL_W];
endmodule

// File: rtl/scan_digit_pick.sv
// 4-to-1 selection of the BCD value for the chosen digit.
module scan_digit_pick
  import scan_pkg::*;
(
  input  bcd_t digits_i [NUM_DIGITS],
  input  sel_t sel_i,
  output bcd_t bcd_o
);
  assign bcd_o = digits_i[sel_i];
endmodule

// File: rtl/scan_onehot.sv
// 2-to-4 decoder from selector value to digit-common enable.
module scan_onehot
  import scan_pkg::*;
(
  input  sel_t sel_i,
  output en_t  en_o
);
  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_line
    assign en_o[k] = (sel_i == sel_t'(k));
  end
endmodule

// File: rtl/scan_bcd_seg.sv
// BCD to segment pattern, bit 0 = a ... bit 6 = g. Codes above 9 are dark.
module scan_bcd_seg
  import scan_pkg::*;
(
  input  bcd_t bcd_i,
  output seg_t seg_o
);
  always_comb begin
    case (bcd_i)
      4'd0:    seg_o = 7'b011_1111;
      4'd1:    seg_o = 7'b000_0110;
      4'd2:    seg_o = 7'b101_1011;
      4'd3:    seg_o = 7'b100_1111;
      4'd4:    seg_o = 7'b110_0110;
      4'd5:    seg_o = 7'b110_1101;
      4'd6:    seg_o = 7'b111_1101;
      4'd7:    seg_o = 7'b000_0111;
      4'd8:    seg_o = 7'b111_1111;
      4'd9:    seg_o = 7'b110_1111;
      default: seg_o = '0;
    endcase
  end
endmodule

// File: rtl/digit_scanner.sv
// Multiplexed digit scanner. The selector from the ripple divider is sampled
// on the rising edge. When the sample differs from the digit being shown, one
// blank cycle is inserted: enables go low while the new segment pattern loads.
module digit_scanner
  import scan_pkg::*;
#(
  parameter int unsigned DWELL_LOG2 = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [BUS_W-1:0] digits_i,
  output logic [NUM_DIGITS-1:0] en_o,
  output logic [SEG_W-1:0] seg_o
);
  localparam int unsigned CHAIN = DWELL_LOG2 + SEL_W;

  sel_t rip_sel;
  sel_t sel_s;
  sel_t shown_q;
  bcd_t digit_arr [NUM_DIGITS];
  bcd_t picked;
  seg_t seg_w;
  en_t  onehot_w;
  en_t  en_q;
  seg_t seg_q;

  for (genvar k = 0; k < NUM_DIGITS; k++) begin : g_unpack
    assign digit_arr[k] = digits_i[k*BCD_W +: BCD_W];
  end

  scan_ripple_sel #(.STAGES(CHAIN)) u_ripple (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .sel_o (rip_sel)
  );

  scan_digit_pick u_pick (
    .digits_i(digit_arr),
    .sel_i   (sel_s),
    .bcd_o   (picked)
  );

  scan_onehot u_onehot (
    .sel_i(sel_s),
    .en_o (onehot_w)
  );

  scan_bcd_seg u_seg (
    .bcd_i(picked),
    .seg_o(seg_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_s   <= '0;
      shown_q <= '0;
      en_q    <= '0;
      seg_q   <= '0;
    end else begin
      sel_s <= rip_sel;
      seg_q <= seg_w;
      if (sel_s != shown_q) begin
        shown_q <= sel_s;
        en_q    <= '0;
      end else begin
        en_q    <= onehot_w;
      end
    end
  end

  assign en_o  = en_q;
  assign seg_o = seg_q;
endmodule

// File: rtl/scan_chk.sv
module scan_chk
  import scan_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic [BUS_W-1:0] digits_i,
  input logic [NUM_DIGITS-1:0] en_o,
  input logic [SEG_W-1:0] seg_o
);
  function automatic bcd_t lit_value(logic [BUS_W-1:0] d, en_t e);
    bcd_t r = '0;
    for (int k = 0; k < NUM_DIGITS; k++) if (e[k]) r = d[k*BCD_W +: BCD_W];
    return r;
  endfunction

  function automatic en_t rot_up(en_t e);
    return {e[NUM_DIGITS-2:0], e[NUM_DIGITS-1]};
  endfunction

  // R3
  one_lit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(en_o));

  // R5
  no_direct_swap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o != '0 && $past(en_o) != '0) |-> (en_o == $past(en_o)));

  // R5
  short_blank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(en_o) != '0 && en_o == '0) |=> (en_o != '0));

  // R2
  next_digit_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o != '0 && $past(en_o) == '0 && $past(en_o, 2) != '0)
      |-> (en_o == rot_up($past(en_o, 2))));

  // R8
  dark_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o != '0 && lit_value($past(digits_i), en_o) > 4'd9) |-> (seg_o == '0));
endmodule

bind digit_scanner scan_chk u_scan_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .digits_i(digits_i),
  .en_o    (en_o),
  .seg_o   (seg_o)
);

// File: tb/digit_scanner_bench.sv
`timescale 1ns/1ps
module digit_scanner_bench;
  localparam int DWELL_LOG2 = 2;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] digits = 16'h0000;
  wire  [3:0]  en;
  wire  [6:0]  seg;

  always #2 clk = ~clk;

  digit_scanner #(.DWELL_LOG2(DWELL_LOG2)) u_digit_scanner (
    .clk_i   (clk),
    .rst_ni  (rst_n),
    .digits_i(digits),
    .en_o    (en),
    .seg_o   (seg)
  );

  typedef struct packed {
    logic [3:0] en;
    logic [6:0] seg;
  } exp_t;

  exp_t q[$];
  int   total = 0;
  int   bad = 0;
  bit   done = 0;
  int   m_neg = 0;
  int   m_samp = 0;
  int   m_shown = 0;
  logic [3:0] prev_en = 4'h0;
  exp_t got;

  function automatic logic [6:0] ref_seg(logic [3:0] b);
    case (b)
      4'd0: return 7'h3F;
      4'd1: return 7'h06;
      4'd2: return 7'h5B;
      4'd3: return 7'h4F;
      4'd4: return 7'h66;
      4'd5: return 7'h6D;
      4'd6: return 7'h7D;
      4'd7: return 7'h07;
      4'd8: return 7'h7F;
      4'd9: return 7'h6F;
      default: return 7'h00; // R8
    endcase
  endfunction

  task automatic chk(string req, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  // Driver side of the scoreboard: push what the outputs must be after this edge.
  task automatic push_expected();
    exp_t e;
    if (m_samp != m_shown) begin
      e.en  = 4'h0;                                  // R5 blank
      e.seg = ref_seg(digits[m_samp*4 +: 4]);        // R7
      m_shown = m_samp;
    end else begin
      e.en  = 4'b0001 << m_shown;                    // R4
      e.seg = ref_seg(digits[m_shown*4 +: 4]);       // R6
    end
    q.push_back(e);
    m_samp = (m_neg >> DWELL_LOG2) % 4;              // R2
  endtask

  always @(negedge clk) if (rst_n) m_neg++;
  always @(posedge clk) if (rst_n) push_expected();

  // Monitor side of the scoreboard.
  always @(posedge clk) begin
    #1;
    if (rst_n && q.size() > 0) begin
      got = q.pop_front();
      chk("R2/R4/R5 enable", {12'h0, en}, {12'h0, got.en});
      chk("R6/R7/R8 segments", {9'h0, seg}, {9'h0, got.seg});
      chk("R3 one-hot", {15'h0, ($countones(en) <= 1)}, 16'h1);
      chk("R5 no direct swap",
          {15'h0, (prev_en != 0 && en != 0 && en != prev_en)}, 16'h0);
      prev_en = en;
    end
  end

  task automatic hold(logic [15:0] v, int cycles);
    @(negedge clk); #1;
    digits = v;
    repeat (cycles) @(posedge clk);
  endtask

  task automatic summary();
    $display("  test done: total=%0d bad=%0d", total, bad);
  endtask

  initial begin
    digits = 16'h2355;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 reset enables", {12'h0, en}, 16'h0);
    chk("R1 reset segments", {9'h0, seg}, 16'h0);
    @(negedge clk); #1;
    rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 first digit lit", {12'h0, en}, 16'h0001);
    repeat (36) @(posedge clk);
    hold(16'h9870, 40);
    hold(16'hFA3B, 40);               // R8 codes 10..15 on three digits
    hold(16'hCDEF, 20);               // R8 all digits dark
    for (int i = 0; i < 12; i++) hold(16'h1111 * (i % 10) + 16'h0123, 3); // R6 tracking
    hold(16'h4161, 40);
    repeat (2) @(posedge clk);
    #1;
    done = 1;
    summary();
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog R2 scan did not finish");
      summary();
      $finish;
    end
  end
endmodule